// File: doc/BRIEF.md
# Serial CRC Generator and Checker with Selectable Polynomial

This block divides a serial bit stream by a generator polynomial over GF(2), taking one bit per clock. Modulo-2 division means subtraction is a plain XOR. The feedback register is wired so that feeding message bits in computes the remainder of the message times x^m divided by the generator, where m is the degree. This gives the same result as appending m zero bits and dividing, but costs no extra cycles.

In generate mode, the remainder is shifted out MSB first after the final message bit. The sender appends it to the message, and the result is then an exact multiple of the generator. In check mode, the received message with its CRC is run through the same division. The block reports an error when the remainder is not zero.

A two-bit select chooses one of three generators. The select and the mode are sampled only on the first bit of each message.

Top module: `crc_serial_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it, `in_ready` is 1 and `out_valid`, `out_last`, `chk_done` and `chk_err` are 0.
- R2: `poly_sel` chooses the generator, with the top term implicit in each case. Code 0 selects x^12+x^11+x^3+x^2+x+1, which gives a 12-bit CRC. Code 1 selects x^16+x^15+x^2+1, which gives a 16-bit CRC. Codes 2 and 3 both select x^16+x^12+x^5+1, which gives a 16-bit CRC.
- R3: `mode`=0 is generate mode. When the bit marked `in_last` is accepted, the next m cycles present the remainder of (message·x^m) mod P on `out_bit`, MSB first, with `out_valid` high. `out_last` is high only on the final bit.
- R4: `in_ready` is 0 while the remainder is being shifted out, and input offered during that time is discarded.
- R5: A message with its generated CRC appended passes the check-mode division with no error.
- R6: `mode`=1 is check mode. One cycle after the last bit is accepted, `chk_done` pulses for one cycle. `chk_err` is high in that same cycle exactly when the remainder is nonzero, so every single-bit error is flagged.
- R7: `mode` and `poly_sel` are sampled only on a message's first accepted bit. Changing them later in the message has no effect on that message.
- R8: The division register starts from all zeros for every message, so the result of one message never depends on an earlier message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input bit is offered |
| in_bit | input | 1 | Serial message bit, first bit is the highest power |
| in_last | input | 1 | Marks the final bit of the message |
| mode | input | 1 | 0 = generate, 1 = check (sampled on the first bit) |
| poly_sel | input | 2 | Generator select (sampled on the first bit) |
| in_ready | output | 1 | The block can accept a bit |
| out_valid | output | 1 | A CRC bit is present on `out_bit` |
| out_bit | output | 1 | CRC bit, MSB first |
| out_last | output | 1 | Final CRC bit |
| chk_done | output | 1 | Check-mode result is valid this cycle |
| chk_err | output | 1 | Nonzero remainder on a checked message |

## Verification
The assertions check, on every cycle, that the CRC output runs without a gap until `out_last` and that its bit counter stays within the selected degree. They also check that the register is empty when a shift-out ends, that the sampled select holds steady inside a message, and that an error is never flagged without `chk_done`. Only the bench scenarios can show the arithmetic itself. These cover an exhaustive sweep of 8-bit messages for every generator, CRC round trips through check mode, every single-bit corruption of selected codewords, and select and mode changes made in the middle of a message.

// File: rtl/crc_serial_engine.sv
module crc_serial_engine #(
  parameter int REG_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_bit,
  input  logic       in_last,
  input  logic       mode,
  input  logic [1:0] poly_sel,
  output logic       in_ready,
  output logic       out_valid,
  output logic       out_bit,
  output logic       out_last,
  output logic       chk_done,
  output logic       chk_err
);
  localparam logic [REG_W-1:0] GEN_A = REG_W'(16'h080F);
  localparam logic [REG_W-1:0] GEN_B = REG_W'(16'h8005);
  localparam logic [REG_W-1:0] GEN_C = REG_W'(16'h1021);
  localparam int CW = $clog2(REG_W);

  function automatic logic [REG_W-1:0] gen_of(input logic [1:0] s);
    case (s)
      2'd0:    return GEN_A;
      2'd1:    return GEN_B;
      default: return GEN_C;
    endcase
  endfunction

  function automatic logic [CW-1:0] top_of(input logic [1:0] s);
    return (s == 2'd0) ? CW'(11) : CW'(REG_W - 1);
  endfunction

  function automatic logic [REG_W-1:0] mask_of(input logic [1:0] s);
    return (s == 2'd0) ? REG_W'(16'h0FFF) : {REG_W{1'b1}};
  endfunction

  logic [REG_W-1:0] crc_q;
  logic [CW-1:0]    cnt_q;
  logic [1:0]       sel_q;
  logic             mode_q, busy_q, shift_q, done_q, err_q;

  wire take  = in_valid & in_ready;
  wire first = take & ~busy_q;

  logic [1:0]       sel_c;
  logic             mode_c;
  logic [CW-1:0]    top_c, top_q;
  logic [REG_W-1:0] nxt_c;

  assign sel_c  = first ? poly_sel : sel_q;
  assign mode_c = first ? mode : mode_q;
  assign top_c  = top_of(sel_c);
  assign top_q  = top_of(sel_q);
  assign nxt_c  = ({crc_q[REG_W-2:0], 1'b0}
                   ^ ((crc_q[top_c] ^ in_bit) ? gen_of(sel_c) : '0)) & mask_of(sel_c);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q   <= '0;
      cnt_q   <= '0;
      sel_q   <= '0;
      mode_q  <= 1'b0;
      busy_q  <= 1'b0;
      shift_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (shift_q) begin
        cnt_q <= cnt_q + CW'(1);
        crc_q <= {crc_q[REG_W-2:0], 1'b0} & mask_of(sel_q);
        if (cnt_q == top_q) begin
          shift_q <= 1'b0;
          crc_q   <= '0;
        end
      end else if (take) begin
        if (first) begin
          sel_q  <= poly_sel;
          mode_q <= mode;
        end
        busy_q <= ~in_last;
        if (!in_last) begin
          crc_q <= nxt_c;
        end else if (!mode_c) begin
          crc_q   <= nxt_c;
          cnt_q   <= '0;
          shift_q <= 1'b1;
        end else begin
          crc_q  <= '0;
          done_q <= 1'b1;
          err_q  <= (nxt_c != '0);
        end
      end
    end
  end

  assign in_ready  = ~shift_q;
  assign out_valid = shift_q;
  assign out_bit   = shift_q & crc_q[top_q];
  assign out_last  = shift_q & (cnt_q == top_q);
  assign chk_done  = done_q;
  assign chk_err   = err_q;

  p_stream_gapless_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid);
  p_stream_ends_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_last));
  p_count_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_q |-> (cnt_q <= top_q));
  p_clear_after_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_q) |-> (crc_q == '0));
  p_sel_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(sel_q) && $stable(mode_q));
  p_err_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_err |-> chk_done);
endmodule

// File: tb/crc_serial_engine_tb_top.sv
module crc_serial_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, in_last = 1'b0, mode = 1'b0;
  logic [1:0] poly_sel = 2'd0;
  logic in_ready, out_valid, out_bit, out_last, chk_done, chk_err;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  crc_serial_engine dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_last(in_last), .mode(mode), .poly_sel(poly_sel), .in_ready(in_ready),
    .out_valid(out_valid), .out_bit(out_bit), .out_last(out_last),
    .chk_done(chk_done), .chk_err(chk_err)
  );

  function automatic int deg_of(input logic [1:0] s);
    return (s == 2'd0) ? 12 : 16;
  endfunction

  function automatic logic [15:0] ref_rem(input logic [1:0] s, input logic [31:0] bits, input int n);
    logic [15:0] g, r, msk;
    int d;
    d = deg_of(s);
    g = (s == 2'd0) ? 16'h080F : (s == 2'd1) ? 16'h8005 : 16'h1021;
    msk = (d == 12) ? 16'h0FFF : 16'hFFFF;
    r = '0;
    for (int i = 0; i < n + d; i++) begin
      logic b, t;
      b = (i < n) ? bits[n-1-i] : 1'b0;
      t = r[d-1];
      r = ((r << 1) | {15'd0, b}) & msk;
      if (t) r = r ^ g;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_msg(input logic md, input logic [1:0] s, input logic [31:0] bits, input int n,
                         output logic [15:0] crc, output logic err, output logic done,
                         output logic shape_ok);
    int d;
    d = deg_of(s);
    crc = '0; err = 1'b0; done = 1'b0; shape_ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_bit   = bits[n-1-i];
      in_last  = (i == n - 1);
      mode     = (i == 0) ? md : ~md;
      poly_sel = (i == 0) ? s : ((s == 2'd0) ? 2'd2 : 2'd0);
    end
    @(negedge clk);
    if (!md) begin
      in_valid = 1'b1; in_bit = 1'b1; in_last = 1'b1; mode = 1'b1;
      for (int k = 0; k < d; k++) begin
        if (!out_valid || in_ready || (out_last !== (k == d - 1))) shape_ok = 1'b0;
        crc = {crc[14:0], out_bit};
        @(negedge clk);
      end
      in_valid = 1'b0; in_last = 1'b0;
      if (out_valid || !in_ready) shape_ok = 1'b0;
    end else begin
      done = chk_done;
      err  = chk_err;
      in_valid = 1'b0; in_last = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] crc, exp;
    logic err, done, ok;
    logic [31:0] cw;
    repeat (3) @(negedge clk);
    check("R1 ready", {31'd0, in_ready}, 32'd1);
    check("R1 outputs idle", {28'd0, out_valid, out_last, chk_done, chk_err}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    check("R1 after release", {30'd0, in_ready, out_valid}, 32'd2);

    for (int s = 0; s < 3; s++) begin
      for (int m = 0; m < 256; m++) begin
        run_msg(1'b0, 2'(s), 32'(m), 8, crc, err, done, ok);
        exp = ref_rem(2'(s), 32'(m), 8);
        check("R3 R8 generated remainder", {16'd0, crc}, {16'd0, exp});
        check("R4 shift-out shape and ready low", {31'd0, ok}, 32'd1);
        cw = (32'(m) << deg_of(2'(s))) | 32'(crc);
        run_msg(1'b1, 2'(s), cw, 8 + deg_of(2'(s)), crc, err, done, ok);
        check("R5 R7 codeword accepted", {30'd0, done, err}, 32'd2);
      end
    end

    for (int s = 0; s < 4; s++) begin
      for (int n = 1; n <= 12; n++) begin
        logic [31:0] msg;
        msg = 32'h00000B5D & ((32'd1 << n) - 1);
        run_msg(1'b0, 2'(s), msg, n, crc, err, done, ok);
        exp = ref_rem((s == 3) ? 2'd2 : 2'(s), msg, n);
        check("R2 selected generator and length", {16'd0, crc}, {16'd0, exp});
      end
    end

    for (int s = 0; s < 3; s++) begin
      for (int v = 0; v < 4; v++) begin
        logic [31:0] msg;
        int n;
        msg = (v == 0) ? 32'h00 : (v == 1) ? 32'hA5 : (v == 2) ? 32'hFF : 32'h3C;
        run_msg(1'b0, 2'(s), msg, 8, crc, err, done, ok);
        n = 8 + deg_of(2'(s));
        cw = (msg << deg_of(2'(s))) | 32'(crc);
        for (int p = 0; p < n; p++) begin
          logic [31:0] bad;
          bad = cw ^ (32'd1 << p);
          run_msg(1'b1, 2'(s), bad, n, crc, err, done, ok);
          check("R6 single-bit error flagged", {30'd0, done, err}, 32'd3);
          check("R6 reference nonzero", {31'd0, ref_rem(2'(s), bad, n) != 16'd0}, 32'd1);
        end
      end
    end

    @(negedge clk);
    check("R6 done is a pulse", {31'd0, chk_done}, 32'd0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule